// File: doc/BRIEF.md
# Packed Truncating Float-to-Integer Converter

This block converts packed IEEE-754 floating-point lanes held in a 128-bit word into packed signed 32-bit integers. The fraction is always discarded, so the result rounds toward zero. A one-bit mode input picks the lane layout. Single mode converts four single-precision lanes. Double mode converts two double-precision lanes and returns zeros in the upper half of the result.

Any lane that cannot be represented as a signed 32-bit value produces the integer-indefinite pattern 0x80000000 and raises the invalid condition. This covers values whose truncated magnitude is out of range, infinities and NaNs. A lane that drops nonzero fraction bits raises the precision condition. Both conditions are ORed across the active lanes and collected into sticky flags.

An invalid-mask input travels with each operand. When the mask is set, an invalid result is written normally. When it is clear, the result still appears with its valid strobe, but a fault output rises and the write enable falls so that the consumer can discard the result. The pipeline has a fixed depth of two and accepts a new operand on every cycle.

Top module: `pk_trunc_cvt`

## Requirements
- R1: Every lane rounds toward zero: positive values round down and negative values round up. For example, 1.5 gives 1 and -2.75 gives -2.
- R2: With in_mode = 0, source bits [32i+31:32i] for i = 0..3 are read as a single-precision value, and its integer result goes to out_data[32i+31:32i].
- R3: With in_mode = 1, source bits [63:0] are converted into out_data[31:0] and source bits [127:64] into out_data[63:32]. out_data[127:64] is zero.
- R4: A lane holding an infinity or a NaN of either sign produces 0x80000000 and raises the invalid condition.
- R5: A lane whose truncated value lies outside [-2^31, 2^31-1] produces 0x80000000 and raises invalid. A value that truncates to exactly -2^31 is valid, including one with a discarded fraction.
- R6: A valid lane that discards nonzero fraction bits raises the precision condition. This includes values in (-1, 0) and nonzero subnormals, which both give 0. Zeros of either sign raise nothing.
- R7: flag_invalid and flag_precision are the OR of the condition over all active lanes. Once set, they stay set until reset. An invalid lane never contributes to precision.
- R8: With in_mask = 1, an invalid result gives out_wr_en = 1 and out_fault = 0. With in_mask = 0, it gives out_valid = 1, out_fault = 1 and out_wr_en = 0, and out_data still carries 0x80000000 in the invalid lanes.
- R9: An operand accepted with in_valid in cycle c appears with out_valid in cycle c+2. Operands may be presented on consecutive cycles.
- R10: After reset, out_valid, out_data, out_wr_en, out_fault and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_mode | input | 1 | 0: four single lanes, 1: two double lanes |
| in_data | input | 128 | Packed floating-point source |
| in_mask | input | 1 | 1: invalid results are written normally |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_data | output | 128 | Packed signed 32-bit results |
| out_wr_en | output | 1 | Result may be written |
| out_fault | output | 1 | Unmasked invalid result |
| flag_invalid | output | 1 | Sticky invalid flag |
| flag_precision | output | 1 | Sticky precision flag |

## Verification
The assertions watch several properties on every cycle:
- the two-stage strobe timing,
- the zero upper half in double mode,
- the fault, write-enable and sticky-flag relations,
- inside each lane, that an invalid lane carries 0x80000000 and never reports precision, and that magnitudes below one give zero.

Only the directed scenarios can show the actual integer values. This includes the lane placement in each mode, the exact boundaries at -2^31 and 2^31-1, and the handling of NaNs, infinities and subnormals. The scenarios are also needed to show that back-to-back operands emerge in order with the right data.

// File: rtl/pk_cvt_pkg.sv
// Package: shared formats and constants for the packed truncating converter.
// Assumes IEEE-754 binary32 and binary64 layouts and 32-bit integer results.
package pk_cvt_pkg;

    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int INT_W    = 32;

    // Lane layout selector carried with each operand.
    typedef enum logic {
        MODE_SP = 1'b0,
        MODE_DP = 1'b1
    } cvt_mode_e;

endpackage

// File: rtl/fp_trunc_lane.sv
// Module: fp_trunc_lane
// Converts one floating-point value of a parameterized format into a signed
// integer of OUT_W bits, discarding the fraction (round toward zero).
// Reports lane_inv for NaN, infinity or out-of-range values (the result is then
// the indefinite pattern), and lane_inx when a valid conversion drops fraction bits.
// Assumes OUT_W is a power of two and EXP_W is large enough that the bias
// exceeds OUT_W.
module fp_trunc_lane #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int OUT_W = 32
) (
    input  logic [EXP_W+MAN_W:0] fp_in,
    output logic [OUT_W-1:0]     int_out,
    output logic                 lane_inv,
    output logic                 lane_inx
);

    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int TOP_UNB = OUT_W - 1;
    localparam int SH_W    = $clog2(OUT_W);
    localparam int WIDE_W  = MAN_W + OUT_W + 1;
    localparam logic [OUT_W:0]   LIM_POS = {2'b00, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W:0]   LIM_NEG = {2'b01, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] INDEF   = {1'b1, {(OUT_W-1){1'b0}}};

    logic              sgn;
    logic [EXP_W-1:0]  exp_f;
    logic [MAN_W-1:0]  man_f;
    int                unb;
    logic [SH_W-1:0]   sh;
    logic [WIDE_W-1:0] wide;
    logic [OUT_W:0]    ip;
    logic [OUT_W:0]    neg_ip;
    logic              frac_nz;

    assign sgn   = fp_in[EXP_W+MAN_W];
    assign exp_f = fp_in[EXP_W+MAN_W-1:MAN_W];
    assign man_f = fp_in[MAN_W-1:0];

    // Align the significand so the integer part lands above bit MAN_W.
    always_comb begin
        unb     = int'(exp_f) - BIAS;
        sh      = unb[SH_W-1:0];
        wide    = {{OUT_W{1'b0}}, 1'b1, man_f} << sh;
        ip      = wide[WIDE_W-1:MAN_W];
        neg_ip  = ~ip + 1'b1;
        frac_nz = |wide[MAN_W-1:0];
    end

    // Classify the value and select the integer result and lane conditions.
    always_comb begin
        int_out  = '0;
        lane_inv = 1'b0;
        lane_inx = 1'b0;
        if (exp_f == '1) begin
            lane_inv = 1'b1;
        end else if (unb < 0) begin
            lane_inx = (exp_f != '0) || (man_f != '0);
        end else if (unb > TOP_UNB) begin
            lane_inv = 1'b1;
        end else if (sgn ? (ip > LIM_NEG) : (ip > LIM_POS)) begin
            lane_inv = 1'b1;
        end else begin
            int_out  = sgn ? neg_ip[OUT_W-1:0] : ip[OUT_W-1:0];
            lane_inx = frac_nz;
        end
        if (lane_inv) begin
            int_out = INDEF;
        end
    end

    // Lane-level checks on the classification outcome.
    always_comb begin
        if (!$isunknown(fp_in)) begin
            assert_indef_on_invalid_R4: assert (!lane_inv || int_out == INDEF)
                else $error("invalid lane without indefinite result");
            assert_no_prec_when_invalid_R7: assert (!(lane_inv && lane_inx))
                else $error("invalid lane also reports precision");
            assert_small_mag_zero_R6: assert (int'(exp_f) >= BIAS || (int_out == '0 && !lane_inv))
                else $error("magnitude below one gave nonzero result");
        end
    end

endmodule

// File: rtl/pk_cvt_lanes.sv
// Module: pk_cvt_lanes
// Builds the single- and double-precision lane converters for a DATA_W-bit
// source and selects the packed result and ORed conditions by mode.
// In double mode the result bits above the double lanes are zero.
// Assumes DATA_W is a multiple of 64.
module pk_cvt_lanes
    import pk_cvt_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  cvt_mode_e         mode,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res,
    output logic              any_inv,
    output logic              any_inx
);

    localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_W = 1 + DP_EXP_W + DP_MAN_W;
    localparam int N_SP = DATA_W / SP_W;
    localparam int N_DP = DATA_W / DP_W;

    logic [INT_W-1:0] sp_res [N_SP];
    logic [INT_W-1:0] dp_res [N_DP];
    logic [N_SP-1:0]  sp_inv, sp_inx;
    logic [N_DP-1:0]  dp_inv, dp_inx;

    for (genvar g = 0; g < N_SP; g++) begin : g_sp
        fp_trunc_lane #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W), .OUT_W(INT_W)) u_lane (
            .fp_in   (src[g*SP_W +: SP_W]),
            .int_out (sp_res[g]),
            .lane_inv(sp_inv[g]),
            .lane_inx(sp_inx[g])
        );
    end

    for (genvar g = 0; g < N_DP; g++) begin : g_dp
        fp_trunc_lane #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W), .OUT_W(INT_W)) u_lane (
            .fp_in   (src[g*DP_W +: DP_W]),
            .int_out (dp_res[g]),
            .lane_inv(dp_inv[g]),
            .lane_inx(dp_inx[g])
        );
    end

    // Pack the lane results of the selected format and OR their conditions.
    always_comb begin
        res = '0;
        if (mode == MODE_DP) begin
            for (int i = 0; i < N_DP; i++) res[i*INT_W +: INT_W] = dp_res[i];
            any_inv = |dp_inv;
            any_inx = |dp_inx;
        end else begin
            for (int i = 0; i < N_SP; i++) res[i*INT_W +: INT_W] = sp_res[i];
            any_inv = |sp_inv;
            any_inx = |sp_inx;
        end
    end

endmodule

// File: rtl/cvt_status.sv
// Module: cvt_status
// Output stage: registers the packed result and its strobe, decides the
// write-enable or fault for unmasked invalid results, and keeps the sticky flags.
// Assumes its inputs come from a registered stage one cycle earlier.
module cvt_status #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic              s_mask,
    input  logic [DATA_W-1:0] s_res,
    input  logic              s_inv,
    input  logic              s_inx,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_wr_en,
    output logic              out_fault,
    output logic              flag_invalid,
    output logic              flag_precision
);

    logic unmasked_inv;
    assign unmasked_inv = s_inv & ~s_mask;

    // Register the result, the strobe and the write/fault decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_wr_en <= 1'b0;
            out_fault <= 1'b0;
        end else begin
            out_valid <= s_valid;
            if (s_valid) out_data <= s_res;
            out_wr_en <= s_valid & ~unmasked_inv;
            out_fault <= s_valid & unmasked_inv;
        end
    end

    // Accumulate the sticky exception flags until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_invalid   <= 1'b0;
            flag_precision <= 1'b0;
        end else begin
            flag_invalid   <= flag_invalid   | (s_valid & s_inv);
            flag_precision <= flag_precision | (s_valid & s_inx);
        end
    end

    assert_fault_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_valid && !out_wr_en && flag_invalid))
        else $error("fault without strobe, with write, or without flag");

    assert_write_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> out_valid)
        else $error("write enable without result strobe");

    assert_inv_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_invalid)) |-> flag_invalid)
        else $error("invalid flag cleared without reset");

    assert_prec_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_precision)) |-> flag_precision)
        else $error("precision flag cleared without reset");

endmodule

// File: rtl/pk_trunc_cvt.sv
// Module: pk_trunc_cvt (top)
// Two-stage packed truncating float-to-int converter. Stage one registers the
// operand, mode and mask. The lane converters work between the stages, and
// stage two registers the result, strobes and flags.
// Assumes DATA_W is a multiple of 64. in_mode 0 selects single lanes and
// 1 selects double lanes.
module pk_trunc_cvt
    import pk_cvt_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_mask,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_wr_en,
    output logic              out_fault,
    output logic              flag_invalid,
    output logic              flag_precision
);

    localparam int HALF_W = DATA_W / 2;

    logic              s1_valid;
    cvt_mode_e         s1_mode;
    logic [DATA_W-1:0] s1_data;
    logic              s1_mask;
    logic [DATA_W-1:0] ln_res;
    logic              ln_inv;
    logic              ln_inx;

    // Stage one: capture the operand with its mode and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mode  <= MODE_SP;
            s1_data  <= '0;
            s1_mask  <= 1'b1;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mode <= cvt_mode_e'(in_mode);
                s1_data <= in_data;
                s1_mask <= in_mask;
            end
        end
    end

    pk_cvt_lanes #(.DATA_W(DATA_W)) u_lanes (
        .mode   (s1_mode),
        .src    (s1_data),
        .res    (ln_res),
        .any_inv(ln_inv),
        .any_inx(ln_inx)
    );

    cvt_status #(.DATA_W(DATA_W)) u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .s_valid       (s1_valid),
        .s_mask        (s1_mask),
        .s_res         (ln_res),
        .s_inv         (ln_inv),
        .s_inx         (ln_inx),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_wr_en     (out_wr_en),
        .out_fault     (out_fault),
        .flag_invalid  (flag_invalid),
        .flag_precision(flag_precision)
    );

    assert_stage1_follows_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s1_valid == $past(in_valid)))
        else $error("stage one strobe lost");

    assert_output_follows_stage1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(s1_valid)))
        else $error("output strobe not one cycle after stage one");

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_mode == MODE_DP) |=> (out_data[DATA_W-1:HALF_W] == '0))
        else $error("upper half not cleared in double mode");

endmodule

// File: tb/tb_pk_trunc_cvt.sv
module tb_pk_trunc_cvt;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_mode;
    logic [127:0] in_data;
    logic         in_mask;
    logic         out_valid;
    logic [127:0] out_data;
    logic         out_wr_en;
    logic         out_fault;
    logic         flag_invalid;
    logic         flag_precision;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] IND = 32'h8000_0000;

    always #4 clk = ~clk;

    pk_trunc_cvt dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_data(in_data), .in_mask(in_mask), .out_valid(out_valid),
        .out_data(out_data), .out_wr_en(out_wr_en), .out_fault(out_fault),
        .flag_invalid(flag_invalid), .flag_precision(flag_precision)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_ctl(input string req, input logic v, input logic inv,
                           input logic prc, input logic wr, input logic flt);
        chk(req, "out_valid", 128'(out_valid), 128'(v));
        chk(req, "flag_invalid", 128'(flag_invalid), 128'(inv));
        chk(req, "flag_precision", 128'(flag_precision), 128'(prc));
        chk(req, "out_wr_en", 128'(out_wr_en), 128'(wr));
        chk(req, "out_fault", 128'(out_fault), 128'(flt));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_data = '0; in_mask = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present one operand at a negedge and wait until its result is visible.
    task automatic run1(input logic mode, input logic [127:0] d, input logic mask);
        in_valid = 1'b1; in_mode = mode; in_data = d; in_mask = mask;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();  // R10
        do_reset();
        chk("R10", "out_data", out_data, '0);
        chk_ctl("R10", 0, 0, 0, 0, 0);
    endtask

    task automatic t_single();  // R1, R2
        do_reset();
        run1(1'b0, {32'h42C80000, 32'hC0300000, 32'h3FC00000, 32'h00000000}, 1'b1);
        chk("R1_R2", "single lanes", out_data, {32'd100, 32'hFFFFFFFE, 32'd1, 32'd0});
        chk_ctl("R1", 1, 0, 1, 1, 0);
        do_reset();
        run1(1'b0, {32'h4B000000, 32'h80000000, 32'h42C80000, 32'h00000000}, 1'b1);
        chk("R2", "exact single lanes", out_data, {32'h00800000, 32'd0, 32'd100, 32'd0});
        chk_ctl("R6", 1, 0, 0, 1, 0);
    endtask

    task automatic t_double();  // R3
        do_reset();
        run1(1'b1, {64'hC1CDCD6500000000, 64'h401E000000000000}, 1'b1);
        chk("R3", "double lanes", out_data, {64'd0, 32'hC4653600, 32'd7});
        chk_ctl("R3", 1, 0, 1, 1, 0);
    endtask

    task automatic t_range();  // R5
        do_reset();
        run1(1'b1, {64'hC1E0000000000000, 64'h41DFFFFFFFC00000}, 1'b1);
        chk("R5", "double limits", out_data, {64'd0, IND, 32'h7FFFFFFF});
        chk_ctl("R5", 1, 0, 0, 1, 0);
        do_reset();
        run1(1'b1, {64'hC1E0000000100000, 64'h0}, 1'b1);
        chk("R5", "-2^31-0.5", out_data, {64'd0, IND, 32'd0});
        chk_ctl("R5", 1, 0, 1, 1, 0);
        do_reset();
        run1(1'b0, {32'h4F000000, 32'h4F32D05E, 32'hCF000000, 32'h3F800000}, 1'b1);
        chk("R5", "single out of range", out_data, {IND, IND, IND, 32'd1});
        chk_ctl("R5", 1, 1, 0, 1, 0);
    endtask

    task automatic t_special();  // R4
        do_reset();
        run1(1'b0, {32'h7FC00000, 32'h7F800000, 32'hFF800000, 32'hFFC00000}, 1'b1);
        chk("R4", "nan and inf", out_data, {IND, IND, IND, IND});
        chk_ctl("R4", 1, 1, 0, 1, 0);
    endtask

    task automatic t_precision();  // R6
        do_reset();
        run1(1'b0, {32'h00000001, 32'hBF000000, 32'h80000001, 32'h3F800000}, 1'b1);
        chk("R6", "small magnitudes", out_data, {32'd0, 32'd0, 32'd0, 32'd1});
        chk_ctl("R6", 1, 0, 1, 1, 0);
    endtask

    task automatic t_mask();  // R8, R7
        do_reset();
        run1(1'b0, {32'h40000000, 32'h40000000, 32'h40000000, 32'h7FC00000}, 1'b0);
        chk("R8", "unmasked data", out_data, {32'd2, 32'd2, 32'd2, IND});
        chk_ctl("R8", 1, 1, 0, 0, 1);
        run1(1'b0, {32'h3FC00000, 32'h40000000, 32'h40000000, 32'h40000000}, 1'b1);
        chk("R7", "clean after invalid", out_data, {32'd1, 32'd2, 32'd2, 32'd2});
        chk_ctl("R7", 1, 1, 1, 1, 0);
        run1(1'b0, {32'h40000000, 32'h40000000, 32'h40000000, 32'h40000000}, 1'b1);
        chk_ctl("R7", 1, 1, 1, 1, 0);
    endtask

    task automatic t_pipeline();  // R9
        do_reset();
        in_valid = 1'b1; in_mode = 1'b0; in_mask = 1'b1;
        in_data = {32'h0, 32'h0, 32'h0, 32'h3F800000};
        @(negedge clk);
        chk("R9", "valid after one cycle", 128'(out_valid), 128'(0));
        in_mode = 1'b1; in_data = {64'hC1E0000000000000, 64'h401E000000000000};
        @(negedge clk);
        chk("R9", "first result", out_data, {96'd0, 32'd1});
        chk("R9", "first valid", 128'(out_valid), 128'(1));
        in_mode = 1'b0; in_data = {4{32'h42C80000}};
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "second result", out_data, {64'd0, IND, 32'd7});
        chk("R9", "second valid", 128'(out_valid), 128'(1));
        @(negedge clk);
        chk("R9", "third result", out_data, {4{32'd100}});
        chk("R9", "third valid", 128'(out_valid), 128'(1));
        @(negedge clk);
        chk("R9", "idle valid", 128'(out_valid), 128'(0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_double();
        t_range();
        t_special();
        t_precision();
        t_mask();
        t_pipeline();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule